// File: doc/BRIEF.md
# Keyboard Matrix Scanner

This block walks the rows of a key switch matrix and reads the return (column) lines on every row. It debounces each closure and turns every accepted key into an 8-bit code. The code also records the levels of the control and shift lines. Accepted codes are queued in an eight-entry FIFO, and the host drains that FIFO through a simple pop port. An interrupt line stays high for as long as at least one code is waiting.

The scan runs in one of two row formats:

- **Binary-row format:** a 3-bit row number is placed on the scan lines and an external decoder expands it to eight rows, giving 64 keys.
- **One-cold format:** the block drives four lines directly, one low at a time, giving 32 keys.

Rollover is chosen by an input:

- **Rollover mode:** every key is debounced and entered on its own.
- **Lockout mode:** a key is entered only while it is the only key down, and any overlap of keys suppresses entry until the matrix is clear.

The scan step length comes from a programmable divider.

Top module: `kbd_matrix_scan`

## Requirements
- R1: An entered code is {ctrl_line, shift_line, row[2:0], col[2:0]}, with the modifier bits taken at the level the pin has (1 = open). The key at row 2, column 4 with both modifier lines high gives 8'hD4.
- R2: When scan_decoded = 0, scan_lines = {1'b0, row}, where row counts 0,1,…,7 and then wraps. Each row is held for 8*(step_div+1) clocks. ret_in[c] = 1 means the key at (row, c) is closed.
- R3: When scan_decoded = 1, scan_lines cycles 4'b1110, 4'b1101, 4'b1011, 4'b0111 for rows 0 to 3, and bit 5 of every entered code is 0. Mode inputs change only under reset.
- R4: In rollover mode (lockout_en = 0), a key is entered once it has been seen closed on two consecutive scans of its row. Keys held at the same time are each entered.
- R5: A key yields exactly one entry per press. It must be seen open before it can be entered again.
- R6: In lockout mode (lockout_en = 1), a key found alone in one full frame is entered at the end of the second following frame in which it is still the only closed key.
- R7: In lockout mode, if two keys are seen together, or a second key appears while the first is pending, nothing is entered until every key is released.
- R8: The FIFO holds 8 codes. A key accepted while the FIFO is full is dropped.
- R9: irq is high exactly when the FIFO holds at least one code.
- R10: A pulse on rd_en pops the oldest code into rd_data on the next clock and clears underrun. A pulse on an empty FIFO leaves rd_data unchanged and sets underrun.
- R11: While rst_n is low, the row is 0, the FIFO is empty, irq = 0, rd_data = 0 and underrun = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_decoded | input | 1 | 1 = four one-cold scan lines, 0 = 3-bit binary row number |
| lockout_en | input | 1 | 1 = two-key lockout, 0 = N-key rollover |
| step_div | input | DIV_W | Scan step length is 8*(step_div+1) clocks |
| ret_in | input | 8 | Return lines, 1 = closed key on the driven row |
| ctrl_line | input | 1 | Control modifier level, copied to code bit 7 |
| shift_line | input | 1 | Shift modifier level, copied to code bit 6 |
| rd_en | input | 1 | Pop one code from the FIFO |
| scan_lines | output | 4 | Row drive |
| rd_data | output | 8 | Last popped key code |
| irq | output | 1 | FIFO not empty |
| underrun | output | 1 | Last pop found the FIFO empty |

## Verification
The in-line assertions check the following on every cycle:

- the row changes only at a step boundary;
- the FIFO count never exceeds its depth and does not move while the FIFO is full and not being read;
- irq rises only after an entry;
- an empty pop holds rd_data and raises underrun;
- one-cold codes never carry bit 5.

Only the bench scenarios can show the rest:

- the code layout;
- the single entry per press;
- the two-frame lockout acceptance window;
- the rejection of overlapping keys;
- dropping the ninth key when the FIFO is full.

These depend on the key timing over several frames.

// File: rtl/kbd_matrix_scan.sv
module kbd_matrix_scan #(
  parameter int DIV_W = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_decoded,
  input  logic             lockout_en,
  input  logic [DIV_W-1:0] step_div,
  input  logic [7:0]       ret_in,
  input  logic             ctrl_line,
  input  logic             shift_line,
  input  logic             rd_en,
  output logic [3:0]       scan_lines,
  output logic [7:0]       rd_data,
  output logic             irq,
  output logic             underrun
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {LK_IDLE, LK_PEND, LK_HELD, LK_BLOCK} lk_t;

  // scan timing: col sweeps each clock, evaluation in the last sweep of a step
  logic [2:0]       col, row;
  logic [DIV_W-1:0] pre;

  wire       last_sweep = (pre == step_div);
  wire       step_end   = last_sweep && (col == 3'd7);
  wire [2:0] last_row   = scan_decoded ? 3'd3 : 3'd7;
  wire       frame_end  = step_end && (row == last_row);
  wire       closed     = last_sweep && ret_in[col];
  wire [5:0] kidx       = {row, col};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0;
      pre <= '0;
      row <= '0;
    end else begin
      col <= col + 3'd1;
      if (col == 3'd7) pre <= last_sweep ? '0 : pre + DIV_W'(1);
      if (step_end)    row <= (row == last_row) ? 3'd0 : row + 3'd1;
    end
  end

  assign scan_lines = scan_decoded ? ~(4'b0001 << row[1:0]) : {1'b0, row};

  // rollover: per-key state 0 open, 1 seen once, 2 entered
  logic [1:0] kst [64];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) kst[i] <= 2'd0;
    end else if (last_sweep) begin
      if (ret_in[col]) begin
        if (kst[kidx] != 2'd2) kst[kidx] <= kst[kidx] + 2'd1;
      end else begin
        kst[kidx] <= 2'd0;
      end
    end
  end

  wire nk_push = !lockout_en && closed && (kst[kidx] == 2'd1);

  // lockout: per-frame census of closed keys
  lk_t        lk_st;
  logic [1:0] fcnt;
  logic [5:0] fkey, cand;
  logic       lk_pass;

  wire [1:0] cnt_now = (closed && fcnt != 2'd2) ? fcnt + 2'd1 : fcnt;
  wire [5:0] key_now = closed ? kidx : fkey;
  wire       alone   = (cnt_now == 2'd1) && (key_now == cand);
  wire       lk_push = lockout_en && frame_end && (lk_st == LK_PEND) && alone && lk_pass;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_st   <= LK_IDLE;
      fcnt    <= '0;
      fkey    <= '0;
      cand    <= '0;
      lk_pass <= 1'b0;
    end else if (last_sweep) begin
      fcnt <= frame_end ? 2'd0 : cnt_now;
      fkey <= key_now;
      if (frame_end) begin
        case (lk_st)
          LK_IDLE: begin
            if (cnt_now == 2'd1) begin
              lk_st   <= LK_PEND;
              cand    <= key_now;
              lk_pass <= 1'b0;
            end else if (cnt_now == 2'd2) begin
              lk_st <= LK_BLOCK;
            end
          end
          LK_PEND: begin
            if (cnt_now == 2'd0) lk_st <= LK_IDLE;
            else if (!alone)     lk_st <= LK_BLOCK;
            else if (lk_pass)    lk_st <= LK_HELD;
            else                 lk_pass <= 1'b1;
          end
          default: if (cnt_now == 2'd0) lk_st <= LK_IDLE;
        endcase
      end
    end
  end

  wire       push      = nk_push | lk_push;
  wire [7:0] push_code = {ctrl_line, shift_line, lockout_en ? cand : kidx};

  // code FIFO
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire wr = push && (cnt != CW'(DEPTH));
  wire rd = rd_en && (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      rd_data  <= '0;
      underrun <= 1'b0;
    end else begin
      if (wr) begin
        mem[wp] <= push_code;
        wp      <= wp + PW'(1);
      end
      if (rd) begin
        rd_data <= mem[rp];
        rp      <= rp + PW'(1);
      end
      if (rd_en) underrun <= (cnt == '0);
      cnt <= cnt + CW'(wr) - CW'(rd);
    end
  end

  assign irq = (cnt != '0);

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step_end |=> $stable(row)); // R2
  AST_DEC_BIT5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && scan_decoded) |-> !push_code[5]); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R8
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && !rd_en) |=> (cnt == CW'(DEPTH))); // R8
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(push)); // R9
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !irq) |=> (underrun && $stable(rd_data))); // R10
  AST_GOOD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && irq) |=> !underrun); // R10
endmodule

// File: tb/kbd_matrix_scan_tb.sv
module kbd_matrix_scan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 64;

  // {row[2:0], col[2:0], ctrl, shift, expected code}
  localparam logic [15:0] VEC [6] = '{
    {3'd2, 3'd4, 1'b1, 1'b1, 8'hD4},
    {3'd0, 3'd0, 1'b0, 1'b0, 8'h00},
    {3'd7, 3'd7, 1'b1, 1'b0, 8'hBF},
    {3'd5, 3'd1, 1'b0, 1'b1, 8'h69},
    {3'd3, 3'd6, 1'b1, 1'b1, 8'hDE},
    {3'd6, 3'd2, 1'b0, 1'b0, 8'h32}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scan_decoded = 1'b0, lockout_en = 1'b0;
  logic [7:0] step_div = 8'd0;
  logic [7:0] ret_in;
  logic       ctrl_line = 1'b0, shift_line = 1'b0, rd_en = 1'b0;
  logic [3:0] scan_lines;
  logic [7:0] rd_data;
  logic       irq, underrun;
  logic [7:0] keys [8];
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_matrix_scan u_dut (
    .clk(clk), .rst_n(rst_n), .scan_decoded(scan_decoded), .lockout_en(lockout_en),
    .step_div(step_div), .ret_in(ret_in), .ctrl_line(ctrl_line), .shift_line(shift_line),
    .rd_en(rd_en), .scan_lines(scan_lines), .rd_data(rd_data), .irq(irq), .underrun(underrun)
  );

  always_comb begin
    ret_in = 8'h00;
    if (scan_decoded) begin
      for (int r = 0; r < 4; r++) if (scan_lines[r] == 1'b0) ret_in = keys[r];
    end else begin
      ret_in = keys[scan_lines[2:0]];
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_keys();
    for (int r = 0; r < 8; r++) keys[r] = 8'h00;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic dec, input logic lock, input logic [7:0] div);
    @(negedge clk);
    rst_n = 1'b0; scan_decoded = dec; lockout_en = lock; step_div = div;
    clear_keys();
    waitc(3);
    rst_n = 1'b1;
  endtask

  task automatic read_one(output logic [7:0] d, output logic u);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
    u = underrun;
  endtask

  task automatic tap(input int r, input int c, input int hold);
    keys[r][c] = 1'b1;
    waitc(hold * FRAME);
    keys[r][c] = 1'b0;
    waitc(2 * FRAME);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2, prev;
    logic u;
    clear_keys();
    waitc(2);
    // R11: reset state
    chk("R11 irq", {7'd0, irq}, 8'h00);
    chk("R11 underrun", {7'd0, underrun}, 8'h00);
    chk("R11 rd_data", rd_data, 8'h00);
    chk("R11 scan_lines", {4'd0, scan_lines}, 8'h00);

    // R2: binary rows, 16-clock steps with step_div=1
    do_reset(1'b0, 1'b0, 8'd1);
    waitc(8);
    for (int r = 0; r < 9; r++) begin
      chk("R2 scan row", {4'd0, scan_lines}, 8'(r % 8));
      waitc(16);
    end

    // R1/R2/R4/R5/R9/R10: vector table, rollover mode
    do_reset(1'b0, 1'b0, 8'd0);
    foreach (VEC[i]) begin
      ctrl_line  = VEC[i][9];
      shift_line = VEC[i][8];
      keys[VEC[i][15:13]][VEC[i][12:10]] = 1'b1;
      waitc(4 * FRAME);
      chk("R9 irq with data", {7'd0, irq}, 8'h01);
      keys[VEC[i][15:13]][VEC[i][12:10]] = 1'b0;
      waitc(2 * FRAME);
      read_one(d, u);
      chk("R1 code", d, VEC[i][7:0]);
      chk("R10 underrun clear", {7'd0, u}, 8'h00);
      chk("R9 irq after pop", {7'd0, irq}, 8'h00);
      read_one(d2, u);
      chk("R5 single entry", {7'd0, u}, 8'h01);
      chk("R10 rd_data held", d2, d);
    end
    ctrl_line = 1'b0; shift_line = 1'b0;

    // R4: two concurrent keys both entered
    keys[1][3] = 1'b1; keys[4][0] = 1'b1;
    waitc(4 * FRAME);
    clear_keys();
    waitc(2 * FRAME);
    read_one(d, u);
    read_one(d2, u);
    chk("R4 both keys", {7'd0, ((d == 8'h0B && d2 == 8'h20) || (d == 8'h20 && d2 == 8'h0B))}, 8'h01);
    chk("R4 second pop ok", {7'd0, u}, 8'h00);

    // R8: nine keys, ninth dropped
    for (int k = 0; k < 9; k++) tap(k / 8, k % 8, 3);
    chk("R9 irq full", {7'd0, irq}, 8'h01);
    for (int k = 0; k < 8; k++) begin
      read_one(d, u);
      chk("R8 fifo order", d, 8'(k));
    end
    prev = d;
    read_one(d, u);
    chk("R8 ninth dropped", {7'd0, u}, 8'h01);
    chk("R10 empty keeps data", d, prev);

    // R3: one-cold rows
    do_reset(1'b1, 1'b0, 8'd0);
    waitc(4);
    for (int r = 0; r < 8; r++) begin
      chk("R3 scan pattern", {4'd0, scan_lines}, {4'd0, ~(4'b0001 << (r % 4))});
      waitc(8);
    end
    ctrl_line = 1'b1; shift_line = 1'b1;
    tap(3, 1, 4);
    read_one(d, u);
    chk("R3 code bit5 zero", d, 8'hD9);
    ctrl_line = 1'b0; shift_line = 1'b0;

    // R6: lockout single key
    do_reset(1'b0, 1'b1, 8'd0);
    ctrl_line = 1'b1; shift_line = 1'b1;
    tap(2, 4, 5);
    read_one(d, u);
    chk("R6 lockout accept", d, 8'hD4);
    read_one(d, u);
    chk("R6 once per press", {7'd0, u}, 8'h01);
    ctrl_line = 1'b0; shift_line = 1'b0;

    // R7: two keys together
    keys[1][1] = 1'b1; keys[5][5] = 1'b1;
    waitc(5 * FRAME);
    clear_keys();
    waitc(2 * FRAME);
    chk("R7 together ignored", {7'd0, irq}, 8'h00);

    // R7: second key while first pending
    keys[3][2] = 1'b1;
    waitc(20);
    keys[6][7] = 1'b1;
    waitc(5 * FRAME);
    keys[6][7] = 1'b0;
    waitc(3 * FRAME);
    chk("R7 no entry until all open", {7'd0, irq}, 8'h00);
    clear_keys();
    waitc(2 * FRAME);
    chk("R7 pending rejected", {7'd0, irq}, 8'h00);

    // R6: recovery after release
    tap(3, 2, 5);
    read_one(d, u);
    chk("R6 recovery", d, 8'h1A);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule